// File: doc/BRIEF.md
# Vectored Interrupt Controller with Indexed Enables

This block collects 64 level-sensitive interrupt sources and turns them into two request lines, one normal and one fast, for a host processor. Software reaches it through a simple 32-bit register bus with byte offsets in word steps. Each register that is indexed by source is split into two words: the low word covers sources 0 to 31 and the high word covers sources 32 to 63, at bit position N-32.

A source is pending when its enable bit is set and either its raw input or its software force bit is high. A per-source route bit sends a pending source to the fast path or keeps it on the normal path. Software can set or clear a single enable by writing a source number to one of two dedicated registers, so no read-modify-write of the enable words is needed. Normal sources carry a 4-bit level. A level mask filters which normal sources may raise the normal request. Two vector registers name the winning source on each path.

Top module: `vic_idx`

## Requirements
- R1: After reset the enable, route, force and level registers are all zero and the level mask is 0xF. With both enable words at zero, neither request output asserts, whatever the source inputs are, and both vector registers read 0xFFFFFFFF.
- R2: Writing a number N below 64 to offset 0x08 sets enable bit N and leaves every other enable bit unchanged. A written value of 64 or more changes no enable bit.
- R3: Writing a number N below 64 to offset 0x0C clears enable bit N and leaves every other enable bit unchanged.
- R4: The enable words can be written and read whole: offset 0x14 holds sources 0-31 and offset 0x10 holds sources 32-63.
- R5: The route words (0x1C for sources 0-31, 0x18 for sources 32-63) steer sources. A 1 sends a pending source to the fast path and a 0 keeps it on the normal path.
- R6: Pending = (raw input OR force bit) AND enable. The raw inputs read at 0x4C (low) and 0x48 (high). The force words are read/write at 0x54 (low) and 0x50 (high). Normal pending (route 0) reads at 0x5C/0x58 and fast pending (route 1) reads at 0x64/0x60.
- R7: Eight level registers sit at offset 0x20 + 4*(7-x) for x = 0..7. Register x covers sources 8x to 8x+7, and source 8x+j uses bits [4j+3:4j]. The registers read back what was written.
- R8: The level mask sits in bits [3:0] of offset 0x04. A mask of 0xF lets every level through. Any other mask value lets a normal pending source through only if its level is strictly above the mask.
- R9: Offset 0x40 returns the winning normal source as {source number in [31:16], level in [3:0]}, with zeros elsewhere. The winner is the highest level among the normal sources that pass the mask, and a tie goes to the higher source number. It reads 0xFFFFFFFF when no normal source passes.
- R10: Offset 0x44 returns the highest-numbered fast pending source in bits [31:16], with the low 16 bits zero. It reads 0xFFFFFFFF when no source is fast pending.
- R11: The request outputs are registered. One clock after a change, `irq_norm` is the OR of the normal sources that pass the mask, and `irq_fast` is the OR of the fast pending set.
- R12: Offsets that hold no register (for example 0x00 and 0x68) read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset of the register (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| src | input | 64 | Level-sensitive interrupt sources |
| irq_norm | output | 1 | Registered normal request |
| irq_fast | output | 1 | Registered fast request |

## Verification
Selection is driven with several source patterns. Two level-0 sources in the low word show whether ties go to the higher number. A level-5 source in the low word against one in the high word shows both that ties go to the higher number and that high-word sources sit at bit N-32. Setting the mask at the shared level and then one below it shows whether the comparison is strict. Route changes split one pending set across both paths and check that the pending words, the vectors and both request lines agree. Force-only stimulus with the raw inputs at zero shows that force bits are ORed in ahead of the enable.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_SRC   = 2 * WORD_W;
  localparam int SRC_W     = $clog2(NUM_SRC);
  localparam int LVL_W     = 4;
  localparam int FLD_PER_W = WORD_W / LVL_W;
  localparam int NUM_LREG  = NUM_SRC / FLD_PER_W;
  localparam int ADDR_W    = 7;

  localparam logic [ADDR_W-1:0] A_MASK   = 7'h04;
  localparam logic [ADDR_W-1:0] A_ENSET  = 7'h08;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 7'h0C;
  localparam logic [ADDR_W-1:0] A_ENHI   = 7'h10;
  localparam logic [ADDR_W-1:0] A_ENLO   = 7'h14;
  localparam logic [ADDR_W-1:0] A_RTHI   = 7'h18;
  localparam logic [ADDR_W-1:0] A_RTLO   = 7'h1C;
  localparam logic [ADDR_W-1:0] A_NVEC   = 7'h40;
  localparam logic [ADDR_W-1:0] A_FVEC   = 7'h44;
  localparam logic [ADDR_W-1:0] A_RAWHI  = 7'h48;
  localparam logic [ADDR_W-1:0] A_RAWLO  = 7'h4C;
  localparam logic [ADDR_W-1:0] A_FRCHI  = 7'h50;
  localparam logic [ADDR_W-1:0] A_FRCLO  = 7'h54;
  localparam logic [ADDR_W-1:0] A_NPHI   = 7'h58;
  localparam logic [ADDR_W-1:0] A_NPLO   = 7'h5C;
  localparam logic [ADDR_W-1:0] A_FPHI   = 7'h60;
  localparam logic [ADDR_W-1:0] A_FPLO   = 7'h64;

  typedef struct packed {
    logic [NUM_SRC-1:0]        en;
    logic [NUM_SRC-1:0]        route;
    logic [NUM_SRC-1:0]        frc;
    logic [NUM_SRC*LVL_W-1:0]  lvl;
    logic [LVL_W-1:0]          mask;
  } vic_state_t;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output vic_state_t        st_q
);
  vic_state_t st_d;
  logic       num_ok;
  logic [NUM_SRC-1:0] num_bit;
  logic       lreg_hit;
  logic [$clog2(NUM_LREG)-1:0] lreg_x;

  assign num_ok   = (wdata[WORD_W-1:SRC_W] == '0);
  assign num_bit  = {{(NUM_SRC-1){1'b0}}, 1'b1} << wdata[SRC_W-1:0];
  assign lreg_hit = (addr[6:5] == 2'b01) && (addr[1:0] == 2'b00);
  assign lreg_x   = ~addr[4:2];

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (lreg_hit) begin
        st_d.lvl[{lreg_x, 5'b0} +: WORD_W] = wdata;
      end else begin
        case (addr)
          A_MASK:  st_d.mask = wdata[LVL_W-1:0];
          A_ENSET: if (num_ok) st_d.en = st_q.en | num_bit;
          A_ENCLR: if (num_ok) st_d.en = st_q.en & ~num_bit;
          A_ENHI:  st_d.en[NUM_SRC-1:WORD_W]    = wdata;
          A_ENLO:  st_d.en[WORD_W-1:0]          = wdata;
          A_RTHI:  st_d.route[NUM_SRC-1:WORD_W] = wdata;
          A_RTLO:  st_d.route[WORD_W-1:0]       = wdata;
          A_FRCHI: st_d.frc[NUM_SRC-1:WORD_W]   = wdata;
          A_FRCLO: st_d.frc[WORD_W-1:0]         = wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q.en    <= '0;
      st_q.route <= '0;
      st_q.frc   <= '0;
      st_q.lvl   <= '0;
      st_q.mask  <= '1;
    end else if (wr_en) begin
      st_q <= st_d;
    end
  end

  // R2
  enset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENSET && num_ok) |=> (st_q.en == ($past(st_q.en) | $past(num_bit))));
  // R2
  enset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENSET && !num_ok) |=> $stable(st_q.en));
  // R3
  enclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENCLR && num_ok) |=> (st_q.en == ($past(st_q.en) & ~$past(num_bit))));
  // R12
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 7'h00) |=> $stable(st_q));
endmodule

// File: rtl/vic_pick.sv
module vic_pick
  import vic_pkg::*;
(
  input  logic [NUM_SRC-1:0]       norm_pend,
  input  logic [NUM_SRC-1:0]       fast_pend,
  input  logic [NUM_SRC*LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]         mask,
  output logic                     norm_any,
  output logic [SRC_W-1:0]         norm_idx,
  output logic [LVL_W-1:0]         norm_lvl,
  output logic                     fast_any,
  output logic [SRC_W-1:0]         fast_idx
);
  logic [NUM_SRC-1:0] cand;
  logic               mask_open;

  assign mask_open = (mask == {LVL_W{1'b1}});

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cand
    assign cand[i] = norm_pend[i] && (mask_open || (lvl[i*LVL_W +: LVL_W] > mask));
  end

  always_comb begin
    norm_any = 1'b0;
    norm_idx = '0;
    norm_lvl = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!norm_any || lvl[i*LVL_W +: LVL_W] >= norm_lvl)) begin
        norm_any = 1'b1;
        norm_idx = SRC_W'(i);
        norm_lvl = lvl[i*LVL_W +: LVL_W];
      end
    end
  end

  always_comb begin
    fast_any = 1'b0;
    fast_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (fast_pend[i]) begin
        fast_any = 1'b1;
        fast_idx = SRC_W'(i);
      end
    end
  end

  always_comb begin
    // R9
    nwin_chk: assert (!norm_any || (norm_pend[norm_idx] &&
                      (mask_open || norm_lvl > mask)));
    // R10
    fwin_chk: assert (!fast_any || fast_pend[fast_idx]);
  end
endmodule

// File: rtl/vic_idx.sv
module vic_idx
  import vic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [6:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src,
  output logic              irq_norm,
  output logic              irq_fast
);
  logic [1:0]         rst_sync_q;
  logic               rst_i_n;
  vic_state_t         st;
  logic [NUM_SRC-1:0] pend, npend, fpend;
  logic               norm_any, fast_any;
  logic [SRC_W-1:0]   norm_idx, fast_idx;
  logic [LVL_W-1:0]   norm_lvl;
  logic               irq_n_d, irq_f_d;
  logic [$clog2(NUM_LREG)-1:0] rd_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  vic_regs u_regs (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr_en (bus_sel && bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .st_q  (st)
  );

  assign pend  = (src | st.frc) & st.en;
  assign npend = pend & ~st.route;
  assign fpend = pend & st.route;

  vic_pick u_pick (
    .norm_pend (npend),
    .fast_pend (fpend),
    .lvl       (st.lvl),
    .mask      (st.mask),
    .norm_any  (norm_any),
    .norm_idx  (norm_idx),
    .norm_lvl  (norm_lvl),
    .fast_any  (fast_any),
    .fast_idx  (fast_idx)
  );

  assign rd_x = ~bus_addr[4:2];

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[6:5] == 2'b01 && bus_addr[1:0] == 2'b00) begin
      bus_rdata = st.lvl[{rd_x, 5'b0} +: WORD_W];
    end else begin
      case (bus_addr)
        A_MASK:  bus_rdata = {{(WORD_W-LVL_W){1'b0}}, st.mask};
        A_ENHI:  bus_rdata = st.en[NUM_SRC-1:WORD_W];
        A_ENLO:  bus_rdata = st.en[WORD_W-1:0];
        A_RTHI:  bus_rdata = st.route[NUM_SRC-1:WORD_W];
        A_RTLO:  bus_rdata = st.route[WORD_W-1:0];
        A_NVEC:  bus_rdata = norm_any ? {{(16-SRC_W){1'b0}}, norm_idx,
                                         {(16-LVL_W){1'b0}}, norm_lvl} : '1;
        A_FVEC:  bus_rdata = fast_any ? {{(16-SRC_W){1'b0}}, fast_idx, 16'h0} : '1;
        A_RAWHI: bus_rdata = src[NUM_SRC-1:WORD_W];
        A_RAWLO: bus_rdata = src[WORD_W-1:0];
        A_FRCHI: bus_rdata = st.frc[NUM_SRC-1:WORD_W];
        A_FRCLO: bus_rdata = st.frc[WORD_W-1:0];
        A_NPHI:  bus_rdata = npend[NUM_SRC-1:WORD_W];
        A_NPLO:  bus_rdata = npend[WORD_W-1:0];
        A_FPHI:  bus_rdata = fpend[NUM_SRC-1:WORD_W];
        A_FPLO:  bus_rdata = fpend[WORD_W-1:0];
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq_n_d = norm_any;
  assign irq_f_d = fast_any;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      irq_norm <= 1'b0;
      irq_fast <= 1'b0;
    end else begin
      irq_norm <= irq_n_d;
      irq_fast <= irq_f_d;
    end
  end

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st.en == '0) |=> (!irq_norm && !irq_fast));
  // R11
  fast_req_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|fpend) |=> irq_fast);
  // R11
  norm_req_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|npend == 1'b0) |=> !irq_norm);
endmodule

// File: tb/vic_idx_bench.sv
`timescale 1ns/1ps
module vic_idx_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [63:0] src;
  logic        irq_norm, irq_fast;

  typedef struct {
    bit          is_irq;
    logic [6:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  int wdog  = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  vic_idx u_vic_idx (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src(src), .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  // monitor: pops expected items mid-cycle and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      act = it.is_irq ? {30'b0, irq_fast, irq_norm} : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h",
                 it.tag, it.addr, act, it.exp);
      end
    end
    wdog++;
    if (wdog > 20000 && !done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    item_t it;
    bus_sel = 1; bus_we = 0; bus_addr = a;
    it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic chk_irq(input bit en, input bit ef, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1; it.addr = 0; it.exp = {30'b0, ef, en}; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
  endtask

  initial begin
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    src = '1;
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state, sources all high
    rd(7'h10, 32'h0, "R1 enable hi");
    rd(7'h14, 32'h0, "R1 enable lo");
    rd(7'h04, 32'hF, "R1 mask");
    rd(7'h40, 32'hFFFF_FFFF, "R1 normal vector");
    rd(7'h44, 32'hFFFF_FFFF, "R1 fast vector");
    rd(7'h5C, 32'h0, "R1 normal pending");
    chk_irq(0, 0, "R1 no request");
    src = '0;
    // R2 set by number
    wr(7'h08, 32'd5);
    rd(7'h14, 32'h20, "R2 set 5");
    wr(7'h08, 32'd40);
    rd(7'h10, 32'h100, "R2 set 40");
    wr(7'h08, 32'd64);
    rd(7'h10, 32'h100, "R2 ignore 64 hi");
    rd(7'h14, 32'h20, "R2 ignore 64 lo");
    // R3 clear by number
    wr(7'h0C, 32'd5);
    rd(7'h14, 32'h0, "R3 clear 5");
    rd(7'h10, 32'h100, "R3 other kept");
    // R4 whole words
    wr(7'h14, 32'hFFFF_FFFF);
    wr(7'h10, 32'hFFFF_FFFF);
    rd(7'h14, 32'hFFFF_FFFF, "R4 lo");
    rd(7'h10, 32'hFFFF_FFFF, "R4 hi");
    // R6 / R9 / R11 basic selection, equal levels
    src[3] = 1; src[10] = 1;
    rd(7'h5C, 32'h408, "R6 normal pending lo");
    rd(7'h40, 32'h000A_0000, "R9 tie to higher");
    chk_irq(1, 0, "R11 normal request");
    // R7 levels
    wr(7'h3C, 32'h5000);
    rd(7'h3C, 32'h5000, "R7 readback x0");
    rd(7'h40, 32'h0003_0005, "R9 higher level wins");
    wr(7'h28, 32'h5);
    rd(7'h28, 32'h5, "R7 readback x5");
    src[40] = 1;
    rd(7'h58, 32'h100, "R6 normal pending hi");
    rd(7'h40, 32'h0028_0005, "R9 tie across words");
    // R8 mask
    wr(7'h04, 32'h5);
    rd(7'h40, 32'hFFFF_FFFF, "R8 strict compare");
    chk_irq(0, 0, "R8 masked request");
    wr(7'h04, 32'h4);
    rd(7'h40, 32'h0028_0005, "R8 above mask");
    chk_irq(1, 0, "R8 unmasked request");
    wr(7'h04, 32'hF);
    // R5 route
    wr(7'h1C, 32'h400);
    wr(7'h18, 32'h100);
    rd(7'h1C, 32'h400, "R5 route lo");
    rd(7'h5C, 32'h8, "R5 normal lo");
    rd(7'h58, 32'h0, "R5 normal hi");
    rd(7'h64, 32'h400, "R5 fast lo");
    rd(7'h60, 32'h100, "R5 fast hi");
    rd(7'h44, 32'h0028_0000, "R10 fast vector");
    rd(7'h40, 32'h0003_0005, "R9 after route");
    chk_irq(1, 1, "R11 both requests");
    // R6 force
    src = '0;
    wr(7'h54, 32'h8);
    rd(7'h54, 32'h8, "R6 force readback");
    rd(7'h4C, 32'h0, "R6 raw lo");
    rd(7'h5C, 32'h8, "R6 forced pending");
    rd(7'h64, 32'h0, "R6 fast lo empty");
    chk_irq(1, 0, "R11 forced request");
    wr(7'h54, 32'h0);
    rd(7'h40, 32'hFFFF_FFFF, "R9 empty");
    rd(7'h44, 32'hFFFF_FFFF, "R10 empty");
    chk_irq(0, 0, "R11 idle");
    // R12 unmapped
    wr(7'h00, 32'hFFFF_FFFF);
    rd(7'h00, 32'h0, "R12 offset 0");
    rd(7'h68, 32'h0, "R12 offset 68");
    rd(7'h10, 32'hFFFF_FFFF, "R12 enables kept");
    // R6 raw readback
    src = 64'h8000_0000_0000_0001;
    rd(7'h48, 32'h8000_0000, "R6 raw hi");
    rd(7'h4C, 32'h1, "R6 raw lo");
    // R4 disable all with sources high
    src = '1;
    wr(7'h10, 32'h0);
    wr(7'h14, 32'h0);
    chk_irq(0, 0, "R4 all disabled");
    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule